// File: doc/BRIEF.md
# Initiator write parity error handler

This block is the error-response logic of a bus master. While the master is in the data phase of one of its own write transactions, the target may report a data parity error on an active-low strobe. The block decides what that report does. Depending on the kind of write and on the control enables, it sets sticky status bits, drives a one-clock active-low system-error pulse, and updates the DMA engine's error and active bits.

The block handles two kinds of write:

- **Ordinary data writes.** The error takes effect on the clock edge that samples it. The DMA engine is aborted. The system error is raised only in extended bus mode, only with the system-error enable set, and only with the recovery enable clear.
- **Interrupt-message writes.** The transaction completes normally, so the error is held pending. It is acted on at the completion strobe, when the system error depends only on the system-error enable.

Software clears the sticky bits by writing 1 to them through a simple write strobe.

Top module: `init_wr_perr_handler`

## Requirements
- R1: A parity error is detected on a clock edge where `wr_phase_vld`=1, `tgt_perr_n`=0 and `cfg_perr_resp_en`=1. For an ordinary write (`wr_is_msg`=0), detection sets `stat_mpe` after that edge.
- R2: With `cfg_perr_resp_en`=0, a strobe inside a write data phase changes no status bit, no DMA bit and no system-error output, and it leaves nothing pending.
- R3: With `wr_phase_vld`=0, `tgt_perr_n`=0 is ignored.
- R4: An ordinary write error drives `serr_n` low only when `ext_mode`=1, `cfg_serr_en`=1 and `cfg_recov_en`=0.
- R5: An interrupt-message write error is held pending until `msg_done`=1. On that edge it sets `stat_mpe`, and it drives `serr_n` low if `cfg_serr_en`=1, whatever the values of `ext_mode` and `cfg_recov_en`.
- R6: `serr_n` is registered and active low. It is low for exactly the one cycle after each qualifying edge. Every such assertion sets `stat_serr` on the same edge.
- R7: An ordinary write error sets `stat_dma_err` and clears `dma_active`.
- R8: An interrupt-message write error changes neither `stat_dma_err` nor `dma_active`. It leaves `stat_mpe` unchanged until completion.
- R9: `dma_start` sets `dma_active`. `dma_done` or an ordinary write error clears it, and a clear wins over a start in the same cycle.
- R10: On `stat_clr_we`=1, each 1 in `stat_clr_data` clears one sticky bit: bit 0 clears `stat_mpe`, bit 1 clears `stat_serr` and bit 2 clears `stat_dma_err`. A set in the same cycle wins over the clear.
- R11: After synchronous reset, `serr_n`=1 and all status bits and `dma_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_phase_vld | input | 1 | Initiator write data phase in progress |
| wr_is_msg | input | 1 | 1 = interrupt-message write, 0 = ordinary write |
| tgt_perr_n | input | 1 | Sampled target parity-error strobe, active low |
| msg_done | input | 1 | Interrupt-message write completed |
| ext_mode | input | 1 | 1 = extended bus mode, 0 = conventional |
| cfg_perr_resp_en | input | 1 | Parity error response enable |
| cfg_serr_en | input | 1 | System error enable |
| cfg_recov_en | input | 1 | Data parity error recovery enable |
| dma_start | input | 1 | DMA start strobe |
| dma_done | input | 1 | DMA normal completion strobe |
| stat_clr_we | input | 1 | Status clear write strobe |
| stat_clr_data | input | 3 | Write-1-to-clear mask for the sticky bits |
| serr_n | output | 1 | System error pulse, active low |
| stat_mpe | output | 1 | Sticky master parity error |
| stat_serr | output | 1 | Sticky system error asserted |
| stat_dma_err | output | 1 | Sticky DMA error |
| dma_active | output | 1 | DMA engine active |

## Verification
The assertions check the following on every cycle:

- Each low `serr_n` cycle comes with both `stat_mpe` and `stat_serr` set.
- An ordinary write error leaves the DMA error bit set and the active bit clear.
- An interrupt-message error alone leaves the DMA error bit stable.
- Nothing becomes pending outside a write data phase.
- A conventional-mode ordinary error never pulses `serr_n`.

Some behaviour only the bench scenarios can show:

- The deferred action of an interrupt-message error at completion time.
- The full enable matrix across both bus modes.
- Set-over-clear priority on the sticky bits.
- Pulse width under back-to-back errors.

// File: rtl/iwpe_pkg.sv
package iwpe_pkg;
    localparam int STAT_W    = 3;
    localparam int ST_MPE    = 0;
    localparam int ST_SERR   = 1;
    localparam int ST_DMAERR = 2;

    // Error events resolved in one cycle
    typedef struct packed {
        logic ord_hit;    // ordinary write error, acted on now
        logic msg_hit;    // interrupt-message write error, deferred
        logic msg_apply;  // deferred error released at completion
    } perr_ev_t;

    typedef struct packed {
        logic resp_en;
        logic serr_en;
        logic recov_en;
        logic ext_mode;
    } err_cfg_t;

    // System-error qualification for both write kinds
    function automatic logic serr_qualify(perr_ev_t ev, err_cfg_t cfg);
        logic ord_q;
        logic msg_q;
        ord_q = ev.ord_hit & cfg.ext_mode & cfg.serr_en & ~cfg.recov_en;
        msg_q = ev.msg_apply & cfg.serr_en;
        return ord_q | msg_q;
    endfunction
endpackage

// File: rtl/iwpe_detect.sv
module iwpe_detect
    import iwpe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_phase_vld,
    input  logic     wr_is_msg,
    input  logic     tgt_perr_n,
    input  logic     msg_done,
    input  logic     resp_en,
    output perr_ev_t ev
);
    logic hit;
    logic pend_q;

    assign hit          = wr_phase_vld & ~tgt_perr_n & resp_en;
    assign ev.ord_hit   = hit & ~wr_is_msg;
    assign ev.msg_hit   = hit & wr_is_msg;
    assign ev.msg_apply = msg_done & (pend_q | ev.msg_hit);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (msg_done)
            pend_q <= 1'b0;
        else if (ev.msg_hit)
            pend_q <= 1'b1;
    end

    // R3: no pending error can arise outside a write data phase
    p_no_pend_outside_phase_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_phase_vld && !pend_q) |=> !pend_q);
    // R2: with response disabled nothing becomes pending
    p_no_pend_resp_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!resp_en && !pend_q) |=> !pend_q);
endmodule

// File: rtl/iwpe_escalate.sv
module iwpe_escalate
    import iwpe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  perr_ev_t ev,
    input  err_cfg_t cfg,
    output logic     serr_fire,
    output logic     serr_n
);
    assign serr_fire = serr_qualify(ev, cfg);

    always_ff @(posedge clk) begin
        if (rst)
            serr_n <= 1'b1;
        else
            serr_n <= ~serr_fire;
    end

    // R4: a conventional-mode ordinary error alone never raises the system error
    p_no_serr_conv_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.ord_hit && !ev.msg_apply && !cfg.ext_mode) |=> serr_n);
    // R5: a released interrupt-message error with the enable set always raises it
    p_msg_serr_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.msg_apply && cfg.serr_en) |=> !serr_n);
endmodule

// File: rtl/iwpe_status.sv
module iwpe_status
    import iwpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  perr_ev_t          ev,
    input  logic              serr_fire,
    input  logic              dma_start,
    input  logic              dma_done,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] stat,
    output logic              dma_active
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[ST_MPE]    = ev.ord_hit | ev.msg_apply;
        set_vec[ST_SERR]   = serr_fire;
        set_vec[ST_DMAERR] = ev.ord_hit;
    end

    assign clr_vec = clr_we ? clr_data : '0;

    for (genvar g = 0; g < STAT_W; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                stat[g] <= 1'b0;
            else
                stat[g] <= set_vec[g] | (stat[g] & ~clr_vec[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dma_active <= 1'b0;
        else if (ev.ord_hit || dma_done)
            dma_active <= 1'b0;
        else if (dma_start)
            dma_active <= 1'b1;
    end

    // R7: an ordinary write error aborts the DMA and flags it
    p_dma_abort_r7: assert property (@(posedge clk) disable iff (rst)
        ev.ord_hit |=> (stat[ST_DMAERR] && !dma_active));
    // R8: an interrupt-message error alone leaves the DMA error bit stable
    p_msg_keeps_dma_r8: assert property (@(posedge clk) disable iff (rst)
        ((ev.msg_hit || ev.msg_apply) && !ev.ord_hit && !clr_vec[ST_DMAERR])
        |=> $stable(stat[ST_DMAERR]));
    // R10: a set beats a clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_vec[ST_MPE] && clr_vec[ST_MPE]) |=> stat[ST_MPE]);
endmodule

// File: rtl/init_wr_perr_handler.sv
module init_wr_perr_handler
    import iwpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_phase_vld,
    input  logic              wr_is_msg,
    input  logic              tgt_perr_n,
    input  logic              msg_done,
    input  logic              ext_mode,
    input  logic              cfg_perr_resp_en,
    input  logic              cfg_serr_en,
    input  logic              cfg_recov_en,
    input  logic              dma_start,
    input  logic              dma_done,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_data,
    output logic              serr_n,
    output logic              stat_mpe,
    output logic              stat_serr,
    output logic              stat_dma_err,
    output logic              dma_active
);
    perr_ev_t          ev;
    err_cfg_t          cfg;
    logic              serr_fire;
    logic [STAT_W-1:0] stat;

    assign cfg.resp_en  = cfg_perr_resp_en;
    assign cfg.serr_en  = cfg_serr_en;
    assign cfg.recov_en = cfg_recov_en;
    assign cfg.ext_mode = ext_mode;

    iwpe_detect u_detect (
        .clk          (clk),
        .rst          (rst),
        .wr_phase_vld (wr_phase_vld),
        .wr_is_msg    (wr_is_msg),
        .tgt_perr_n   (tgt_perr_n),
        .msg_done     (msg_done),
        .resp_en      (cfg_perr_resp_en),
        .ev           (ev)
    );

    iwpe_escalate u_escalate (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cfg       (cfg),
        .serr_fire (serr_fire),
        .serr_n    (serr_n)
    );

    iwpe_status u_status (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .serr_fire  (serr_fire),
        .dma_start  (dma_start),
        .dma_done   (dma_done),
        .clr_we     (stat_clr_we),
        .clr_data   (stat_clr_data),
        .stat       (stat),
        .dma_active (dma_active)
    );

    assign stat_mpe     = stat[ST_MPE];
    assign stat_serr    = stat[ST_SERR];
    assign stat_dma_err = stat[ST_DMAERR];

    // R6: every low system-error cycle carries both sticky flags
    p_serr_flags_r6: assert property (@(posedge clk) disable iff (rst)
        !serr_n |-> (stat_serr && stat_mpe));
endmodule

// File: tb/init_wr_perr_handler_tb_top.sv
`timescale 1ns/1ps
module init_wr_perr_handler_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic wr_phase_vld, wr_is_msg, tgt_perr_n, msg_done, ext_mode;
    logic cfg_perr_resp_en, cfg_serr_en, cfg_recov_en;
    logic dma_start, dma_done, stat_clr_we;
    logic [2:0] stat_clr_data;
    logic serr_n, stat_mpe, stat_serr, stat_dma_err, dma_active;

    int checks = 0;
    int errors = 0;

    // bench-side expected state
    logic m_pend, m_mpe, m_serr, m_derr, m_act, m_serr_n;

    always #10 clk = ~clk;

    init_wr_perr_handler dut_i (
        .clk(clk), .rst(rst), .wr_phase_vld(wr_phase_vld), .wr_is_msg(wr_is_msg),
        .tgt_perr_n(tgt_perr_n), .msg_done(msg_done), .ext_mode(ext_mode),
        .cfg_perr_resp_en(cfg_perr_resp_en), .cfg_serr_en(cfg_serr_en),
        .cfg_recov_en(cfg_recov_en), .dma_start(dma_start), .dma_done(dma_done),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .serr_n(serr_n), .stat_mpe(stat_mpe), .stat_serr(stat_serr),
        .stat_dma_err(stat_dma_err), .dma_active(dma_active)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_serr(logic ord, logic app);
        if (app && cfg_serr_en) return 1'b1;
        if (ord && ext_mode && cfg_serr_en && !cfg_recov_en) return 1'b1;
        return 1'b0;
    endfunction

    // advance one clock: predict from the present inputs, then compare outputs
    task automatic tick();
        logic hit, ord, mh, app, fire;
        hit  = wr_phase_vld && !tgt_perr_n && cfg_perr_resp_en;
        ord  = hit && !wr_is_msg;
        mh   = hit && wr_is_msg;
        app  = msg_done && (m_pend || mh);
        fire = exp_serr(ord, app);
        m_mpe  = (ord || app) || (m_mpe  && !(stat_clr_we && stat_clr_data[0]));
        m_serr = fire         || (m_serr && !(stat_clr_we && stat_clr_data[1]));
        m_derr = ord          || (m_derr && !(stat_clr_we && stat_clr_data[2]));
        if (ord || dma_done) m_act = 1'b0;
        else if (dma_start)  m_act = 1'b1;
        m_pend   = msg_done ? 1'b0 : (m_pend || mh);
        m_serr_n = !fire;
        @(posedge clk);
        @(negedge clk);
        chk(serr_n,       m_serr_n, "R6 serr_n");
        chk(stat_mpe,     m_mpe,    "R1 stat_mpe");
        chk(stat_serr,    m_serr,   "R6 stat_serr");
        chk(stat_dma_err, m_derr,   "R7 stat_dma_err");
        chk(dma_active,   m_act,    "R9 dma_active");
    endtask

    task automatic idle();
        wr_phase_vld = 0; wr_is_msg = 0; tgt_perr_n = 1; msg_done = 0;
        dma_start = 0; dma_done = 0; stat_clr_we = 0; stat_clr_data = 3'b000;
    endtask

    task automatic perr(input logic msg);
        wr_phase_vld = 1; wr_is_msg = msg; tgt_perr_n = 0;
    endtask

    task automatic clear_all();
        idle(); stat_clr_we = 1; stat_clr_data = 3'b111; tick(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        ext_mode = 0; cfg_perr_resp_en = 1; cfg_serr_en = 1; cfg_recov_en = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_pend = 0; m_mpe = 0; m_serr = 0; m_derr = 0; m_act = 0; m_serr_n = 1;
        // R11 reset state
        chk(serr_n, 1'b1, "R11 serr_n"); chk(stat_mpe, 1'b0, "R11 mpe");
        chk(stat_serr, 1'b0, "R11 serr"); chk(stat_dma_err, 1'b0, "R11 derr");
        chk(dma_active, 1'b0, "R11 act");

        // R1 / R4 / R7: ordinary error in conventional mode, DMA running
        dma_start = 1; tick(); idle();
        perr(0); tick(); idle();
        chk(stat_mpe, 1'b1, "R1 mpe set"); chk(serr_n, 1'b1, "R4 no serr conv");
        chk(stat_dma_err, 1'b1, "R7 derr"); chk(dma_active, 1'b0, "R7 act cleared");
        // R10 clear only bit 0
        stat_clr_we = 1; stat_clr_data = 3'b001; tick(); idle();
        chk(stat_mpe, 1'b0, "R10 mpe cleared"); chk(stat_dma_err, 1'b1, "R10 derr kept");
        clear_all();

        // R2 response disabled
        cfg_perr_resp_en = 0; ext_mode = 1; dma_start = 1; tick(); idle();
        perr(0); tick(); idle(); tick();
        chk(stat_mpe, 1'b0, "R2 mpe"); chk(serr_n, 1'b1, "R2 serr_n");
        chk(dma_active, 1'b1, "R2 act kept"); chk(stat_dma_err, 1'b0, "R2 derr");
        perr(1); tick(); idle(); msg_done = 1; tick(); idle();
        chk(stat_mpe, 1'b0, "R2 msg nothing pending");
        cfg_perr_resp_en = 1;

        // R3 strobe outside data phase
        tgt_perr_n = 0; tick(); idle(); tick();
        chk(stat_mpe, 1'b0, "R3 ignored"); chk(dma_active, 1'b1, "R3 act kept");

        // R4 extended mode pulse, then R6 single-cycle width
        perr(0); tick(); idle();
        chk(serr_n, 1'b0, "R4 serr asserted"); chk(stat_serr, 1'b1, "R6 serr sticky");
        tick();
        chk(serr_n, 1'b1, "R6 one cycle"); chk(stat_serr, 1'b1, "R6 sticky held");
        clear_all();
        cfg_recov_en = 1; perr(0); tick(); idle();
        chk(serr_n, 1'b1, "R4 recovery blocks"); chk(stat_mpe, 1'b1, "R4 mpe still set");
        clear_all();

        // R5 / R8 interrupt-message write, conventional, recovery set
        ext_mode = 0; dma_start = 1; tick(); idle();
        perr(1); tick(); idle(); tick();
        chk(stat_mpe, 1'b0, "R8 deferred"); chk(dma_active, 1'b1, "R8 act kept");
        chk(serr_n, 1'b1, "R8 no early serr");
        msg_done = 1; tick(); idle();
        chk(stat_mpe, 1'b1, "R5 mpe at done"); chk(serr_n, 1'b0, "R5 serr");
        chk(stat_dma_err, 1'b0, "R8 derr unchanged"); chk(dma_active, 1'b1, "R8 act");
        clear_all();
        cfg_serr_en = 0; perr(1); tick(); idle(); msg_done = 1; tick(); idle();
        chk(serr_n, 1'b1, "R5 no serr when disabled"); chk(stat_mpe, 1'b1, "R5 mpe");

        // R10 set wins over clear; R9 clear wins over start
        perr(0); stat_clr_we = 1; stat_clr_data = 3'b111; dma_start = 1; tick(); idle();
        chk(stat_mpe, 1'b1, "R10 set wins"); chk(stat_dma_err, 1'b1, "R10 derr set wins");
        chk(dma_active, 1'b0, "R9 error over start");
        dma_start = 1; tick(); idle();
        dma_start = 1; dma_done = 1; tick(); idle();
        chk(dma_active, 1'b0, "R9 done over start");

        // R6 back-to-back pulses
        cfg_serr_en = 1; cfg_recov_en = 0; ext_mode = 1;
        perr(0); tick(); chk(serr_n, 1'b0, "R6 first");
        tick(); idle(); chk(serr_n, 1'b0, "R6 second");
        tick(); chk(serr_n, 1'b1, "R6 released");

        // constrained random mix checked against the bench model
        for (int i = 0; i < 4000; i++) begin
            wr_phase_vld     = ($urandom_range(0, 1) == 1);
            wr_is_msg        = ($urandom_range(0, 2) == 0);
            tgt_perr_n       = ($urandom_range(0, 9) > 2);
            msg_done         = ($urandom_range(0, 5) == 0);
            dma_start        = ($urandom_range(0, 4) == 0);
            dma_done         = ($urandom_range(0, 9) == 0);
            stat_clr_we      = ($urandom_range(0, 7) == 0);
            stat_clr_data    = 3'($urandom_range(0, 7));
            if ((i % 97) == 0) begin
                ext_mode         = ($urandom_range(0, 1) == 1);
                cfg_perr_resp_en = ($urandom_range(0, 4) != 0);
                cfg_serr_en      = ($urandom_range(0, 3) != 0);
                cfg_recov_en     = ($urandom_range(0, 2) == 0);
            end
            tick();
        end
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule